// File: doc/BRIEF.md
# Byte-Window Program RAM Loader

This block holds a word-wide instruction memory and lets a host fill it, or read it back, through a single byte-wide data window. The host selects one of four small registers with a 2-bit select code. A word pointer is built from a full low address byte and a narrow high address register. A byte-lane pointer inside the block tracks which byte of the current word the next window access touches. Four window writes gather one word, least significant byte first. On the fourth byte the whole word is written to memory in one cycle, and the word pointer then steps to the next word.

Window reads walk the memory the same way. Each read returns one byte of the addressed word, lowest byte first, and the fourth read steps the word pointer. A control register gates window writes with a load-enable bit and carries a self-clearing bit that sends the pointer back to word zero. A separate fetch port lets the engine that executes the program read whole words by address, with one cycle of latency.

Top module: `prog_ram_loader`

## Requirements
- R1: After reset, load is disabled, the word pointer is 0, the lane pointer is lane 0 and `rdata` is 0.
- R2: Select codes: 0 is control, 1 is the data window, 2 is the low address byte, 3 is the high address register. A read with `rd_en` places the selected register's value on `rdata` one cycle later. `rdata` holds its value otherwise.
- R3: With load enabled, four window writes b0, b1, b2, b3 commit the word {b3,b2,b1,b0} (b0 in bits 7:0) to the addressed word in one cycle, on the fourth write. The fetch port shows memory[`ifetch_addr`] one cycle after the address is presented.
- R4: The word pointer advances by one only after the fourth (most significant) byte of a word. The first three bytes leave it unchanged.
- R5: Only bit 0 of a write to the high address register is kept. That register reads back as {7'b0, pointer bit 8}, so the pointer spans 512 words.
- R6: A window write while load is disabled (control bit 0 = 0) is ignored: memory, the word pointer and the lane pointer are unchanged.
- R7: A control write with bit 1 set returns the word pointer and the lane pointer to 0. Bit 1 is not stored, so the control register reads back as {7'b0, load enable}.
- R8: Writing either address register returns the lane pointer to lane 0.
- R9: Window reads return the bytes of the addressed word lowest byte first. They advance the lane pointer and the word pointer exactly as writes do, whatever the load-enable setting.
- R10: The word pointer wraps from 511 to 0.
- R11: When `wr_en` and `rd_en` are both high, only the write takes effect, and `rdata` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write strobe |
| rd_en | input | 1 | Host register read strobe |
| sel | input | 2 | Register select code |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, registered |
| ifetch_addr | input | 9 | Word address for instruction fetch |
| ifetch_data | output | 32 | Fetched word, one cycle after the address |

## Verification
A lane pointer that has slipped shows at once on the fetch port as a word with its bytes rotated, and on the next window read as the wrong byte. A word pointer that moves too early or too late shows on the next read of the low address register, and as a commit to the neighbouring word. A write that leaks through while load is disabled is caught by the next four enabled bytes landing shifted. A wrap fault shows after the 512th word of the full fill, when the pointer is read back.

// File: rtl/loader_pkg.sv
package loader_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_WIN  = 2'd1,
      SEL_ALO  = 2'd2,
      SEL_AHI  = 2'd3
   } reg_sel_e;

   localparam int CTRL_LOAD_BIT = 0;
   localparam int CTRL_RST_BIT  = 1;
endpackage

// File: rtl/ldr_lane_asm.sv
module ldr_lane_asm #(
   parameter int DATA_W     = 8,
   parameter int WORD_BYTES = 4,
   localparam int LANE_W    = $clog2(WORD_BYTES),
   localparam int WORD_W    = DATA_W * WORD_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   input  logic              capture,
   input  logic [DATA_W-1:0] byte_in,
   output logic [LANE_W-1:0] lane_o,
   output logic              last_o,
   output logic [WORD_W-1:0] word_o
);
   logic [LANE_W-1:0] lane_q;

   assign lane_o = lane_q;
   assign last_o = (lane_q == LANE_W'(WORD_BYTES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)      lane_q <= '0;
      else if (clear)  lane_q <= '0;
      else if (step)   lane_q <= last_o ? '0 : lane_q + LANE_W'(1);
   end

   // lower lanes are held; the top lane comes straight from the bus
   for (genvar i = 0; i < WORD_BYTES - 1; i++) begin : g_hold
      logic [DATA_W-1:0] hold_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            hold_q <= '0;
         else if (capture && lane_q == LANE_W'(i))
            hold_q <= byte_in;
      end
      assign word_o[i*DATA_W +: DATA_W] = hold_q;
   end
   assign word_o[WORD_W-1 -: DATA_W] = byte_in;
endmodule

// File: rtl/ldr_addr_reg.sv
module ldr_addr_reg #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 9,
   localparam int HI_W  = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              incr,
   input  logic [DATA_W-1:0] byte_in,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] addr_q;
   assign addr_o = addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      addr_q <= '0;
      else if (clear)  addr_q <= '0;
      else if (wr_lo)  addr_q[DATA_W-1:0] <= byte_in;
      else if (wr_hi)  addr_q[ADDR_W-1:DATA_W] <= byte_in[HI_W-1:0];
      else if (incr)   addr_q <= addr_q + ADDR_W'(1);
   end

   // R5
   hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !clear) |=> (addr_q[ADDR_W-1:DATA_W] == $past(byte_in[HI_W-1:0])));
endmodule

// File: rtl/ldr_word_mem.sv
module ldr_word_mem #(
   parameter int DATA_W     = 8,
   parameter int WORD_BYTES = 4,
   parameter int ADDR_W     = 9,
   parameter bit FETCH_REG  = 1'b1,
   localparam int LANE_W    = $clog2(WORD_BYTES),
   localparam int WORD_W    = DATA_W * WORD_BYTES,
   localparam int DEPTH     = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wword,
   input  logic [ADDR_W-1:0] haddr,
   input  logic [LANE_W-1:0] hlane,
   output logic [DATA_W-1:0] hbyte,
   input  logic [ADDR_W-1:0] faddr,
   output logic [WORD_W-1:0] fword
);
   logic [WORD_W-1:0] mem [DEPTH];
   logic [WORD_W-1:0] host_word;
   logic [DATA_W-1:0] lanes [WORD_BYTES];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wword;
   end

   assign host_word = mem[haddr];
   for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
      assign lanes[i] = host_word[i*DATA_W +: DATA_W];
   end
   assign hbyte = lanes[hlane];

   if (FETCH_REG) begin : g_fetch_reg
      logic [WORD_W-1:0] fetch_q;
      always_ff @(posedge clk) begin
         if (!rst_n) fetch_q <= '0;
         else        fetch_q <= mem[faddr];
      end
      assign fword = fetch_q;
   end else begin : g_fetch_comb
      assign fword = mem[faddr];
   end
endmodule

// File: rtl/prog_ram_loader.sv
module prog_ram_loader #(
   parameter int DATA_W     = 8,
   parameter int WORD_BYTES = 4,
   parameter int ADDR_W     = 9,
   parameter bit FETCH_REG  = 1'b1,
   localparam int LANE_W    = $clog2(WORD_BYTES),
   localparam int WORD_W    = DATA_W * WORD_BYTES,
   localparam int HI_W      = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [ADDR_W-1:0] ifetch_addr,
   output logic [WORD_W-1:0] ifetch_data
);
   import loader_pkg::*;

   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (ADDR_W <= DATA_W || ADDR_W > 2 * DATA_W) begin : g_bad_addr
      $error("ADDR_W must exceed DATA_W and fit two address registers");
   end
   if (WORD_BYTES < 2 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_bytes
      $error("WORD_BYTES must be a power of two, at least 2");
   end

   reg_sel_e          sel_e;
   logic              load_q;
   logic              win_wr, win_rd, step, commit;
   logic              ctl_wr, rst_hit, alo_wr, ahi_wr, host_rd;
   logic [LANE_W-1:0] lane_q;
   logic              last;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] asm_word;
   logic [DATA_W-1:0] win_byte;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;

   assign sel_e   = reg_sel_e'(sel);
   assign host_rd = rd_en && !wr_en;
   assign win_wr  = wr_en && sel_e == SEL_WIN && load_q;
   assign win_rd  = host_rd && sel_e == SEL_WIN;
   assign step    = win_wr || win_rd;
   assign commit  = win_wr && last;
   assign ctl_wr  = wr_en && sel_e == SEL_CTRL;
   assign rst_hit = ctl_wr && wdata[CTRL_RST_BIT];
   assign alo_wr  = wr_en && sel_e == SEL_ALO;
   assign ahi_wr  = wr_en && sel_e == SEL_AHI;

   always_ff @(posedge clk) begin
      if (!rst_n)      load_q <= 1'b0;
      else if (ctl_wr) load_q <= wdata[CTRL_LOAD_BIT];
   end

   ldr_lane_asm #(.DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (rst_hit || alo_wr || ahi_wr),
      .step    (step),
      .capture (win_wr),
      .byte_in (wdata),
      .lane_o  (lane_q),
      .last_o  (last),
      .word_o  (asm_word)
   );

   ldr_addr_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (rst_hit),
      .wr_lo   (alo_wr),
      .wr_hi   (ahi_wr),
      .incr    (step && last),
      .byte_in (wdata),
      .addr_o  (addr_q)
   );

   ldr_word_mem #(.DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES), .ADDR_W(ADDR_W),
                  .FETCH_REG(FETCH_REG)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (commit),
      .waddr (addr_q),
      .wword (asm_word),
      .haddr (addr_q),
      .hlane (lane_q),
      .hbyte (win_byte),
      .faddr (ifetch_addr),
      .fword (ifetch_data)
   );

   always_comb begin
      unique case (sel_e)
         SEL_CTRL: rd_mux = {{(DATA_W-1){1'b0}}, load_q};
         SEL_WIN:  rd_mux = win_byte;
         SEL_ALO:  rd_mux = addr_q[DATA_W-1:0];
         SEL_AHI:  rd_mux = {{(DATA_W-HI_W){1'b0}}, addr_q[ADDR_W-1:DATA_W]};
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rdata_q <= '0;
      else if (host_rd) rdata_q <= rd_mux;
   end
   assign rdata = rdata_q;

   // R6
   ignored_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == 2'd1 && !load_q) |=> (lane_q == $past(lane_q)) && (addr_q == $past(addr_q)));
   // R7
   rst_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == 2'd0 && wdata[1]) |=> (addr_q == '0) && (lane_q == '0) && (rdata == $past(rdata)));
   // R8
   lane_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel[1]) |=> (lane_q == '0));
   // R4
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !last) |=> (addr_q == $past(addr_q)));
   // R10
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last) |=> (addr_q == $past(addr_q) + ADDR_W'(1)) && (lane_q == '0));
   // R9
   rd_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && sel == 2'd1 && !last) |=> (lane_q == $past(lane_q) + LANE_W'(1)));
   // R11
   rd_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en) |=> $stable(rdata));
endmodule

// File: tb/prog_ram_loader_tb.sv
module prog_ram_loader_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [1:0]  sel = 2'd0;
   logic [7:0]  wdata = 8'd0;
   logic [7:0]  rdata;
   logic [8:0]  ifetch_addr = 9'd0;
   logic [31:0] ifetch_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] m_mem [512];
   int          m_addr = 0;
   int          m_lane = 0;
   bit          m_load = 1'b0;
   logic [7:0]  m_asm [4];
   logic [7:0]  m_rdata = 8'd0;

   always #4 clk = ~clk;

   prog_ram_loader u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
      .wdata(wdata), .rdata(rdata), .ifetch_addr(ifetch_addr), .ifetch_data(ifetch_data)
   );

   function automatic logic [31:0] pat(input int i);
      logic [8:0] a;
      a = 9'(i);
      return {a[7:0] ^ 8'hA5, 8'h3C + a[7:0], a[8:1], ~a[7:0]};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic void m_advance();
      if (m_lane == 3) begin
         m_lane = 0;
         m_addr = (m_addr + 1) % 512;
      end else m_lane++;
   endfunction

   function automatic void m_write(input logic [1:0] s, input logic [7:0] d);
      case (s)
         2'd0: begin
            m_load = d[0];
            if (d[1]) begin m_addr = 0; m_lane = 0; end
         end
         2'd1: if (m_load) begin
            m_asm[m_lane] = d;
            if (m_lane == 3) m_mem[m_addr] = {d, m_asm[2], m_asm[1], m_asm[0]};
            m_advance();
         end
         2'd2: begin m_addr = (m_addr & 256) | int'(d); m_lane = 0; end
         default: begin m_addr = (m_addr & 255) | (int'(d[0]) << 8); m_lane = 0; end
      endcase
   endfunction

   function automatic logic [7:0] m_read(input logic [1:0] s);
      logic [7:0] v;
      case (s)
         2'd0: v = {7'd0, m_load};
         2'd1: begin
            v = m_mem[m_addr][8*m_lane +: 8];
            m_advance();
         end
         2'd2: v = 8'(m_addr);
         default: v = {7'd0, m_addr[8]};
      endcase
      return v;
   endfunction

   // one host cycle; rdata compared against the model afterwards
   task automatic host(input bit w, input bit r, input logic [1:0] s, input logic [7:0] d,
                       input string tag, input bit chk);
      @(negedge clk);
      wr_en = w; rd_en = r; sel = s; wdata = d;
      if (w) m_write(s, d);
      else if (r) m_rdata = m_read(s);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      if (chk) check(tag, {24'd0, rdata}, {24'd0, m_rdata});
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      host(1'b1, 1'b0, s, d, "", 1'b0);
   endtask

   task automatic rd(input logic [1:0] s, input string tag);
      host(1'b0, 1'b1, s, 8'd0, tag, 1'b1);
   endtask

   task automatic fetch(input int a, input string tag);
      @(negedge clk);
      ifetch_addr = 9'(a);
      @(negedge clk);
      check(tag, ifetch_data, m_mem[a]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rdata after reset", {24'd0, rdata}, 32'd0);
      rd(2'd0, "R1 control after reset");
      rd(2'd2, "R1 addr lo after reset");
      rd(2'd3, "R1 addr hi after reset");

      // R3 R4 R10: fill all words, checking the pointer inside the first word
      wr(2'd0, 8'h01);
      rd(2'd0, "R2 control reads load bit");
      for (int i = 0; i < 512; i++) begin
         logic [31:0] v;
         v = pat(i);
         for (int b = 0; b < 4; b++) begin
            wr(2'd1, v[8*b +: 8]);
            if (i == 0 && b < 3) rd(2'd2, "R4 pointer held mid word");
         end
         if (i == 0) rd(2'd2, "R4 pointer after fourth byte");
         if (i == 0) fetch(0, "R3 first word little-end first");
      end
      rd(2'd2, "R10 wrap lo");
      rd(2'd3, "R10 wrap hi");
      fetch(511, "R3 last word");
      fetch(300, "R3 mid word");

      // R9: read back word 5 through the window
      wr(2'd2, 8'd5);
      for (int b = 0; b < 4; b++) rd(2'd1, "R9 window read byte");
      rd(2'd2, "R9 pointer after four reads");

      // R6: disabled writes ignored
      wr(2'd2, 8'd10);
      wr(2'd0, 8'h00);
      wr(2'd1, 8'hEE);
      wr(2'd1, 8'hEE);
      rd(2'd2, "R6 pointer unchanged");
      fetch(10, "R6 memory unchanged");
      wr(2'd0, 8'h01);
      wr(2'd1, 8'h11); wr(2'd1, 8'h22); wr(2'd1, 8'h33); wr(2'd1, 8'h44);
      fetch(10, "R6 lane not moved by disabled writes");
      check("R6 directed word", m_mem[10], 32'h44332211);

      // R8: address write resets the lane
      wr(2'd2, 8'd20);
      wr(2'd1, 8'hAA); wr(2'd1, 8'hBB);
      wr(2'd2, 8'd20);
      wr(2'd1, 8'h01); wr(2'd1, 8'h02); wr(2'd1, 8'h03); wr(2'd1, 8'h04);
      fetch(20, "R8 lane cleared by address write");
      check("R8 directed word", m_mem[20], 32'h04030201);

      // R5: only bit 0 of the high register
      wr(2'd3, 8'hFE);
      rd(2'd3, "R5 high reads 0");
      wr(2'd3, 8'hFF);
      rd(2'd3, "R5 high reads 1");

      // R7: reset bit
      wr(2'd2, 8'hA5);
      wr(2'd1, 8'h77);
      wr(2'd0, 8'h03);
      rd(2'd2, "R7 lo cleared");
      rd(2'd3, "R7 hi cleared");
      rd(2'd0, "R7 reset bit not stored");
      for (int b = 0; b < 4; b++) wr(2'd1, 8'(8'h90 + b));
      fetch(0, "R7 lane cleared");

      // R11: simultaneous write and read
      rd(2'd2, "R11 prior read");
      host(1'b1, 1'b1, 2'd2, 8'h42, "R11 rdata unchanged", 1'b1);
      rd(2'd2, "R11 write took effect");

      // R9 reads with load disabled still advance
      wr(2'd0, 8'h00);
      wr(2'd2, 8'd255);
      for (int b = 0; b < 5; b++) rd(2'd1, "R9 read with load off");
      rd(2'd3, "R9 read crosses into upper half");

      // random mix
      wr(2'd0, 8'h01);
      for (int n = 0; n < 3000; n++) begin
         logic [1:0] s;
         logic [7:0] d;
         int r;
         r = int'($urandom % 100);
         d = 8'($urandom);
         if (r < 50) s = 2'd1;
         else s = 2'($urandom % 4);
         if (s == 2'd0) begin
            d[1] = ($urandom % 10) == 0;
            d[0] = ($urandom % 6) != 0;
         end
         if (r < 65 || (r >= 90 && s != 2'd1)) wr(s, d);
         else rd(s, "R2 random read");
         if (n % 50 == 0) fetch(int'($urandom % 512), "R3 random fetch");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule